// File: doc/BRIEF.md
# Streaming Signed Integer Divider with Selectable Remainder Convention

This block divides a signed numerator by a signed denominator and returns a quotient and a remainder. It takes a new operand pair on every clock cycle, with no stalls, and returns each result a fixed number of cycles later. That delay equals the `STAGES` parameter. The numerator width `NUM_W` and the denominator width `DEN_W` are independent parameters, each from 1 to 64 bits. `STAGES` must lie between 1 and `NUM_W`. The quotient is `NUM_W` bits wide and the remainder is `DEN_W` bits wide.

Each operand pair carries its own convention bit, `in_rem_pos`, which travels down the pipe with it:

- **Truncating convention** (`in_rem_pos` = 0): the quotient rounds toward zero, and the remainder is zero or takes the numerator's sign.
- **Non-negative-remainder convention** (`in_rem_pos` = 1): the remainder is moved into 0 .. |d|-1, and the quotient is moved by one to match.

The core works on magnitudes. It spreads `NUM_W` shift-and-subtract steps evenly across the stages. The last stage then selects one of four fix-up states:

- `FIX_KEEP`: sign-restored truncated result.
- `FIX_DEC`: quotient minus one, remainder |d| - |r|.
- `FIX_INC`: quotient plus one, remainder |d| - |r|.
- `FIX_DIVZ`: defined divide-by-zero output.

The fix-up state is chosen as follows:

- A zero denominator selects `FIX_DIVZ`.
- Otherwise, the non-negative convention with a negative numerator and a non-zero remainder selects `FIX_INC` when the denominator is negative, and `FIX_DEC` otherwise.
- Every other case selects `FIX_KEEP`.

No state is held from one operand to the next, so each operand's fix-up state is chosen fresh.

Top module: `sdiv_pipe`

## Requirements
- R1: A pair accepted with `in_valid`=1 at a clock edge produces its result with `out_valid`=1 exactly `STAGES` edges later. Pairs stream every cycle and come out in order.
- R2: With `in_rem_pos`=0, the quotient is truncated toward zero and the remainder is n - q*d. The remainder is zero or has the numerator's sign. Example: -5 / 3 gives -1 remainder -2.
- R3: With `in_rem_pos`=1 and a positive denominator, a negative truncated remainder is corrected to quotient - 1 and remainder + d. Example: -5 / 3 gives -2 remainder 1.
- R4: With `in_rem_pos`=1 and a negative denominator, a negative truncated remainder is corrected to quotient + 1 and remainder - d. Example: -5 / -3 gives 2 remainder 1.
- R5: When the truncated remainder is zero or positive, both conventions give identical results.
- R6: The most negative numerator divided by -1 gives a quotient that wraps to the most negative value and a remainder of 0, under both conventions.
- R7: A zero denominator sets `out_dz`=1, drives the quotient to all ones, and drives the remainder to the numerator's low `DEN_W` bits (sign-extended when `DEN_W` > `NUM_W`). `out_dz` is 0 for non-zero denominators and whenever `out_valid` is 0.
- R8: While `rst` is 1 at a clock edge, every in-flight valid is cleared, so `out_valid` is 0 after that edge. Pairs presented during reset produce no result.
- R9: At 40-bit numerator width, -83718307840 / 11 gives -7610755258 remainder -2 when truncating, and -7610755259 remainder 9 in the non-negative convention.
- R10: The convention bit applies only to the pair it arrives with. Alternating it on identical back-to-back operands gives alternating results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, clears valid bits |
| in_valid | input | 1 | Operand pair present this cycle |
| in_rem_pos | input | 1 | 1 = non-negative remainder, 0 = truncating |
| in_num | input | NUM_W | Signed numerator |
| in_den | input | DEN_W | Signed denominator |
| out_valid | output | 1 | Result present this cycle |
| out_quo | output | NUM_W | Signed quotient |
| out_rem | output | DEN_W | Signed remainder |
| out_dz | output | 1 | Result came from a zero denominator |

## Verification
The hardest case to reach from the ports is `FIX_INC`. It needs a negative numerator, a negative denominator, a non-zero remainder and the non-negative convention all at once. The wrap of the most negative numerator divided by -1 is just as hard to reach, and random full-width operands almost never produce either. The stimulus therefore aims directed pairs at these cases, and also at a most-negative denominator and at zero denominators. The random pairs draw magnitudes shifted right by a random amount, with random signs, and force a zero denominator about one time in sixty-four. Alternating conventions on identical back-to-back pairs, plus a reset in the middle of a stream, test that the convention and the valid bit stay attached to their own operand.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;

    // Fix-up state chosen in the final stage for each operand.
    typedef enum logic [1:0] {
        FIX_KEEP = 2'd0,
        FIX_DEC  = 2'd1,
        FIX_INC  = 2'd2,
        FIX_DIVZ = 2'd3
    } fix_e;

    // Shift-subtract steps placed in each stage (ceiling division).
    function automatic int unsigned steps_per_stage(int unsigned nw, int unsigned st);
        return (nw + st - 1) / st;
    endfunction

    // Steps actually performed by stage k; trailing stages may do none.
    function automatic int unsigned stage_steps(int unsigned nw, int unsigned st, int unsigned k);
        int unsigned bps;
        bps = steps_per_stage(nw, st);
        if (k * bps >= nw)
            return 0;
        if ((k + 1) * bps > nw)
            return nw - k * bps;
        return bps;
    endfunction

endpackage

// File: rtl/sdiv_prep.sv
`timescale 1ns/1ps
module sdiv_prep #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 24
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             n_neg,
    output logic             d_neg,
    output logic             d_zero,
    output logic [NUM_W-1:0] n_mag,
    output logic [DEN_W-1:0] d_mag,
    output logic [DEN_W-1:0] z_rem
);

    always_comb begin
        n_neg  = num[NUM_W-1];
        d_neg  = den[DEN_W-1];
        n_mag  = n_neg ? (~num + NUM_W'(1)) : num;
        d_mag  = d_neg ? (~den + DEN_W'(1)) : den;
        d_zero = (den == '0);
    end

    // Remainder value reported for a zero denominator.
    generate
        if (DEN_W <= NUM_W) begin : g_narrow
            assign z_rem = num[DEN_W-1:0];
        end else begin : g_wide
            assign z_rem = {{(DEN_W-NUM_W){num[NUM_W-1]}}, num};
        end
    endgenerate

endmodule

// File: rtl/sdiv_iter.sv
`timescale 1ns/1ps
module sdiv_iter #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 24,
    parameter int ITERS = 5
) (
    input  logic [DEN_W-1:0] d_mag,
    input  logic [DEN_W-1:0] rem_i,
    input  logic [NUM_W-1:0] nq_i,
    output logic [DEN_W-1:0] rem_o,
    output logic [NUM_W-1:0] nq_o
);

    // nq holds unconsumed numerator bits at the top and
    // finished quotient bits at the bottom.
    logic [DEN_W:0]   trial;
    logic [DEN_W-1:0] part;
    logic [NUM_W-1:0] nq;

    always_comb begin
        part  = rem_i;
        nq    = nq_i;
        trial = '0;
        for (int i = 0; i < ITERS; i++) begin
            trial = {part, nq[NUM_W-1]};
            nq    = nq << 1;
            if (trial >= {1'b0, d_mag}) begin
                trial = trial - {1'b0, d_mag};
                nq[0] = 1'b1;
            end
            part = trial[DEN_W-1:0];
        end
        rem_o = part;
        nq_o  = nq;
    end

endmodule

// File: rtl/sdiv_fixup.sv
`timescale 1ns/1ps
module sdiv_fixup
    import sdiv_pkg::*;
#(
    parameter int NUM_W = 40,
    parameter int DEN_W = 24
) (
    input  logic             rem_pos,
    input  logic             n_neg,
    input  logic             d_neg,
    input  logic             d_zero,
    input  logic [DEN_W-1:0] d_mag,
    input  logic [DEN_W-1:0] r_mag,
    input  logic [DEN_W-1:0] z_rem,
    input  logic [NUM_W-1:0] q_mag,
    output logic [NUM_W-1:0] quo,
    output logic [DEN_W-1:0] rem
);

    fix_e             kind;
    logic [NUM_W-1:0] q_trunc;
    logic [DEN_W-1:0] r_trunc;
    logic [DEN_W-1:0] r_lift;
    logic             r_below;

    // Select the fix-up state.
    always_comb begin
        r_below = n_neg && (r_mag != '0);
        if (d_zero)
            kind = FIX_DIVZ;
        else if (rem_pos && r_below)
            kind = d_neg ? FIX_INC : FIX_DEC;
        else
            kind = FIX_KEEP;
    end

    // Drive quotient and remainder for that state.
    always_comb begin
        q_trunc = (n_neg ^ d_neg) ? (~q_mag + NUM_W'(1)) : q_mag;
        r_trunc = n_neg ? (~r_mag + DEN_W'(1)) : r_mag;
        r_lift  = d_mag - r_mag;
        unique case (kind)
            FIX_KEEP: begin
                quo = q_trunc;
                rem = r_trunc;
            end
            FIX_DEC: begin
                quo = q_trunc - NUM_W'(1);
                rem = r_lift;
            end
            FIX_INC: begin
                quo = q_trunc + NUM_W'(1);
                rem = r_lift;
            end
            FIX_DIVZ: begin
                quo = '1;
                rem = z_rem;
            end
            default: begin
                quo = q_trunc;
                rem = r_trunc;
            end
        endcase
    end

endmodule

// File: rtl/sdiv_pipe.sv
`timescale 1ns/1ps
module sdiv_pipe
    import sdiv_pkg::*;
#(
    parameter int NUM_W  = 40,
    parameter int DEN_W  = 24,
    parameter int STAGES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_rem_pos,
    input  logic [NUM_W-1:0] in_num,
    input  logic [DEN_W-1:0] in_den,
    output logic             out_valid,
    output logic [NUM_W-1:0] out_quo,
    output logic [DEN_W-1:0] out_rem,
    output logic             out_dz
);

    localparam int LAST = STAGES - 1;

    // Inputs seen by each stage.
    logic             i_v    [STAGES];
    logic             i_mode [STAGES];
    logic             i_nneg [STAGES];
    logic             i_dneg [STAGES];
    logic             i_dz   [STAGES];
    logic [DEN_W-1:0] i_dmag [STAGES];
    logic [DEN_W-1:0] i_zrem [STAGES];
    logic [DEN_W-1:0] i_rem  [STAGES];
    logic [NUM_W-1:0] i_nq   [STAGES];

    // Work results of each stage.
    logic [DEN_W-1:0] w_rem  [STAGES];
    logic [NUM_W-1:0] w_nq   [STAGES];

    // Registers between stages.
    logic             s_v    [STAGES];
    logic             s_mode [STAGES];
    logic             s_nneg [STAGES];
    logic             s_dneg [STAGES];
    logic             s_dz   [STAGES];
    logic [DEN_W-1:0] s_dmag [STAGES];
    logic [DEN_W-1:0] s_zrem [STAGES];
    logic [DEN_W-1:0] s_rem  [STAGES];
    logic [NUM_W-1:0] s_nq   [STAGES];

    // Final-stage side fields, exposed for the checker.
    logic             fin_mode;
    logic             fin_nneg;

    logic [NUM_W-1:0] fx_quo;
    logic [DEN_W-1:0] fx_rem;

    sdiv_prep #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_prep (
        .num    (in_num),
        .den    (in_den),
        .n_neg  (i_nneg[0]),
        .d_neg  (i_dneg[0]),
        .d_zero (i_dz[0]),
        .n_mag  (i_nq[0]),
        .d_mag  (i_dmag[0]),
        .z_rem  (i_zrem[0])
    );

    assign i_v[0]    = in_valid;
    assign i_mode[0] = in_rem_pos;
    assign i_rem[0]  = '0;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            localparam int ITERS = int'(stage_steps(NUM_W, STAGES, k));

            if (k > 0) begin : g_link
                assign i_v[k]    = s_v[k-1];
                assign i_mode[k] = s_mode[k-1];
                assign i_nneg[k] = s_nneg[k-1];
                assign i_dneg[k] = s_dneg[k-1];
                assign i_dz[k]   = s_dz[k-1];
                assign i_dmag[k] = s_dmag[k-1];
                assign i_zrem[k] = s_zrem[k-1];
                assign i_rem[k]  = s_rem[k-1];
                assign i_nq[k]   = s_nq[k-1];
            end

            if (ITERS > 0) begin : g_work
                sdiv_iter #(.NUM_W(NUM_W), .DEN_W(DEN_W), .ITERS(ITERS)) u_iter (
                    .d_mag (i_dmag[k]),
                    .rem_i (i_rem[k]),
                    .nq_i  (i_nq[k]),
                    .rem_o (w_rem[k]),
                    .nq_o  (w_nq[k])
                );
            end else begin : g_idle
                assign w_rem[k] = i_rem[k];
                assign w_nq[k]  = i_nq[k];
            end
        end
    endgenerate

    sdiv_fixup #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_fixup (
        .rem_pos (i_mode[LAST]),
        .n_neg   (i_nneg[LAST]),
        .d_neg   (i_dneg[LAST]),
        .d_zero  (i_dz[LAST]),
        .d_mag   (i_dmag[LAST]),
        .r_mag   (w_rem[LAST]),
        .z_rem   (i_zrem[LAST]),
        .q_mag   (w_nq[LAST]),
        .quo     (fx_quo),
        .rem     (fx_rem)
    );

    // Pipeline registers. Valid bits are reset; data is not.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LAST; k++) begin
            s_v[k]    <= rst ? 1'b0 : i_v[k];
            s_mode[k] <= i_mode[k];
            s_nneg[k] <= i_nneg[k];
            s_dneg[k] <= i_dneg[k];
            s_dz[k]   <= i_dz[k];
            s_dmag[k] <= i_dmag[k];
            s_zrem[k] <= i_zrem[k];
            s_rem[k]  <= w_rem[k];
            s_nq[k]   <= w_nq[k];
        end
        out_valid <= rst ? 1'b0 : i_v[LAST];
        out_dz    <= rst ? 1'b0 : (i_v[LAST] & i_dz[LAST]);
        out_quo   <= fx_quo;
        out_rem   <= fx_rem;
        fin_mode  <= i_mode[LAST];
        fin_nneg  <= i_nneg[LAST];
    end

endmodule

// File: rtl/sdiv_pipe_chk.sv
`timescale 1ns/1ps
module sdiv_pipe_chk #(
    parameter int NUM_W  = 40,
    parameter int DEN_W  = 24,
    parameter int STAGES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [NUM_W-1:0] out_quo,
    input logic [DEN_W-1:0] out_rem,
    input logic             out_dz,
    input logic             fin_mode,
    input logic             fin_nneg
);

    localparam int CW = $clog2(STAGES + 2) + 1;

    // Count of operands accepted but not yet delivered.
    logic [CW-1:0] inflight;

    always_ff @(posedge clk) begin
        if (rst)
            inflight <= '0;
        else
            inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end

    // R8: a reset edge leaves no valid result behind.
    p_reset_clears_r8: assert property (@(posedge clk) rst |=> !out_valid);

    // R1: never more results pending than pipeline stages.
    p_inflight_bound_r1: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(STAGES));

    // R7: the divide-by-zero flag is only raised on a valid result.
    p_dz_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        out_dz |-> out_valid);

    // R7: a divide-by-zero result drives an all-ones quotient.
    p_dz_quo_ones_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dz) |-> (&out_quo));

    // R3: the non-negative convention never yields a negative remainder.
    p_posrem_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_dz && fin_mode) |-> !out_rem[DEN_W-1]);

    // R2: a truncating remainder is zero or has the numerator's sign.
    p_trunc_sign_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_dz && !fin_mode) |->
            ((out_rem == '0) || (out_rem[DEN_W-1] == fin_nneg)));

endmodule

bind sdiv_pipe sdiv_pipe_chk #(
    .NUM_W  (NUM_W),
    .DEN_W  (DEN_W),
    .STAGES (STAGES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_quo   (out_quo),
    .out_rem   (out_rem),
    .out_dz    (out_dz),
    .fin_mode  (fin_mode),
    .fin_nneg  (fin_nneg)
);

// File: tb/sdiv_pipe_bench.sv
`timescale 1ns/1ps
module sdiv_pipe_bench;

    localparam int NUM_W  = 40;
    localparam int DEN_W  = 24;
    localparam int STAGES = 8;
    localparam int RING   = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_rem_pos = 1'b0;
    logic [NUM_W-1:0] in_num = '0;
    logic [DEN_W-1:0] in_den = '0;
    logic             out_valid;
    logic [NUM_W-1:0] out_quo;
    logic [DEN_W-1:0] out_rem;
    logic             out_dz;

    sdiv_pipe #(.NUM_W(NUM_W), .DEN_W(DEN_W), .STAGES(STAGES)) u_sdiv_pipe (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_rem_pos (in_rem_pos),
        .in_num     (in_num),
        .in_den     (in_den),
        .out_valid  (out_valid),
        .out_quo    (out_quo),
        .out_rem    (out_rem),
        .out_dz     (out_dz)
    );

    always #2.5 clk = ~clk;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    int  cyc      = 0;

    // Expected results, indexed by the cycle the operands were driven.
    bit               e_v   [RING];
    logic [NUM_W-1:0] e_q   [RING];
    logic [DEN_W-1:0] e_r   [RING];
    bit               e_dz  [RING];
    string            e_tag [RING];

    localparam logic [NUM_W-1:0] MOST_NEG = {1'b1, {(NUM_W-1){1'b0}}};

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Reference model of both conventions, written from the requirements.
    task automatic model(input logic [NUM_W-1:0] n, input logic [DEN_W-1:0] d, input bit pos,
                         output logic [NUM_W-1:0] q, output logic [DEN_W-1:0] r,
                         output bit dz, output string tag);
        longint ns, ds, qs, rs;
        ns = longint'(signed'(n));
        ds = longint'(signed'(d));
        if (ds == 0) begin
            dz  = 1'b1;
            q   = '1;
            r   = n[DEN_W-1:0];
            tag = "R7";
            return;
        end
        dz  = 1'b0;
        qs  = ns / ds;
        rs  = ns % ds;
        tag = (rs < 0) ? "R2" : "R5";
        if (n == MOST_NEG && ds == -1)
            tag = "R6";
        if (pos && rs < 0) begin
            if (ds > 0) begin
                qs  = qs - 1;
                rs  = rs + ds;
                tag = "R3";
            end else begin
                qs  = qs + 1;
                rs  = rs - ds;
                tag = "R4";
            end
        end
        q = qs[NUM_W-1:0];
        r = rs[DEN_W-1:0];
    endtask

    // Compare outputs against the entry driven STAGES cycles ago.
    task automatic check_out();
        int j;
        j = (cyc + RING - STAGES) % RING;
        chk(out_valid == e_v[j], e_v[j] ? "R1" : "R8", "out_valid",
            64'(out_valid), 64'(e_v[j]));
        if (e_v[j]) begin
            chk(out_quo == e_q[j], e_tag[j], "quotient", 64'(out_quo), 64'(e_q[j]));
            chk(out_rem == e_r[j], e_tag[j], "remainder", 64'(out_rem), 64'(e_r[j]));
            chk(out_dz == e_dz[j], "R7", "dz flag", 64'(out_dz), 64'(e_dz[j]));
        end else begin
            chk(out_dz == 1'b0, "R7", "dz without valid", 64'(out_dz), 64'd0);
        end
    endtask

    // One cycle: check at the falling edge, then drive the next pair.
    task automatic step(input bit r, input bit v, input bit pos,
                        input logic [NUM_W-1:0] n, input logic [DEN_W-1:0] d,
                        input string tag_ovr);
        int i;
        @(negedge clk);
        check_out();
        if (r && !rst) begin
            for (int k = 0; k < RING; k++) e_v[k] = 1'b0;
        end
        rst        = r;
        in_valid   = v;
        in_rem_pos = pos;
        in_num     = n;
        in_den     = d;
        i = cyc % RING;
        e_v[i] = v && !r;
        if (e_v[i]) begin
            model(n, d, pos, e_q[i], e_r[i], e_dz[i], e_tag[i]);
            if (tag_ovr != "") e_tag[i] = tag_ovr;
        end
        cyc++;
    endtask

    function automatic logic [NUM_W-1:0] sn(input longint x);
        return x[NUM_W-1:0];
    endfunction

    function automatic logic [DEN_W-1:0] sd(input longint x);
        return x[DEN_W-1:0];
    endfunction

    initial begin
        logic [63:0]      raw;
        logic [NUM_W-1:0] rn;
        logic [DEN_W-1:0] rd;
        for (int k = 0; k < RING; k++) e_v[k] = 1'b0;
        void'($urandom(32'd20240611));

        // Reset state (R8).
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b0, sn(7), sd(2), "");

        // Directed pairs, streamed back to back.
        step(1'b0, 1'b1, 1'b0, sn(-5), sd(3), "R2");
        step(1'b0, 1'b1, 1'b1, sn(-5), sd(3), "R3");
        step(1'b0, 1'b1, 1'b0, sn(-5), sd(-3), "R2");
        step(1'b0, 1'b1, 1'b1, sn(-5), sd(-3), "R4");
        step(1'b0, 1'b1, 1'b0, sn(5), sd(-3), "R5");
        step(1'b0, 1'b1, 1'b1, sn(5), sd(-3), "R5");
        step(1'b0, 1'b1, 1'b1, sn(-6), sd(3), "R5");
        step(1'b0, 1'b1, 1'b0, sn(-64'd83718307840), sd(11), "R9");
        step(1'b0, 1'b1, 1'b1, sn(-64'd83718307840), sd(11), "R9");
        step(1'b0, 1'b1, 1'b0, MOST_NEG, sd(-1), "R6");
        step(1'b0, 1'b1, 1'b1, MOST_NEG, sd(-1), "R6");
        step(1'b0, 1'b1, 1'b0, sn(-7), sd(0), "R7");
        step(1'b0, 1'b1, 1'b1, sn(123456), sd(0), "R7");
        step(1'b0, 1'b1, 1'b1, sn(-1), {1'b1, {(DEN_W-1){1'b0}}}, "R4");
        step(1'b0, 1'b1, 1'b0, sn(-1), {1'b1, {(DEN_W-1){1'b0}}}, "R2");
        step(1'b0, 1'b0, 1'b1, sn(-9), sd(4), "");
        for (int k = 0; k < 6; k++)
            step(1'b0, 1'b1, k[0], sn(-1000003), sd(-17), "R10");

        // Random stream with a reset in the middle.
        for (int k = 0; k < 4000; k++) begin
            raw = {$urandom(), $urandom()};
            rn  = NUM_W'(raw >> ($urandom() % 64));
            if ($urandom() % 2 == 1) rn = ~rn + NUM_W'(1);
            raw = {$urandom(), $urandom()};
            rd  = DEN_W'(raw >> ($urandom() % 64));
            if ($urandom() % 2 == 1) rd = ~rd + DEN_W'(1);
            if ($urandom() % 64 == 0) rd = '0;
            step((k >= 2000 && k < 2003), ($urandom() % 5) != 0, $urandom() % 2 == 1, rn, rd, "");
        end

        // Drain.
        for (int k = 0; k < STAGES + 3; k++) step(1'b0, 1'b0, 1'b0, '0, '0, "");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule